// File: doc/BRIEF.md
# Real-Time Clock Alarm Interrupt Controller

This block watches the running calendar time of a real-time clock and raises interrupts when the time reaches preset alarm values. It has two alarms. The weekly alarm compares day-of-week, hour and minute. The daily alarm compares hour and minute only. Each alarm has a sticky flag and an enable bit. The weekly alarm drives interrupt line B. The daily alarm drives interrupt line A, and it shares line A with a periodic-interrupt request that is generated outside the block.

Software reaches the block through a small register port: a 4-bit address, 8-bit write data with a write strobe, and read data that follows the address combinationally. Alarm flags are cleared by writing a 0 to their bit, and writing a 1 leaves them alone. This lets software clear one flag without disturbing the other. All time and alarm values are BCD. Everything runs on one clock with a synchronous active-low reset.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset all alarm registers, enables and flags read 0, and both `irq_a_n` and `irq_b_n` are high.
- R2: When the weekly enable (bit 7 of address 0xE) is 1 and the current day-of-week, hour and minute all become equal to the weekly alarm, the weekly flag (bit 1 of address 0xF) sets on that clock edge and `irq_b_n` goes low. A difference in day-of-week alone prevents the match.
- R3: When the daily enable (bit 6 of address 0xE) is 1 and the current hour and minute become equal to the daily alarm, the daily flag (bit 0 of address 0xF) sets and `irq_a_n` goes low. Day-of-week is not compared.
- R4: A flag sets only on the cycle where its comparison changes from false to true. A flag that is cleared while the time still matches stays clear.
- R5: Writing 0 to a flag bit at address 0xF clears that flag and releases its output on the next cycle. Writing 1 to a flag bit has no effect.
- R6: Clearing a flag leaves the enable bits unchanged. The alarm sets again on the next new match.
- R7: An alarm output is low only while both its flag and its enable are 1. Writing the enable to 0 releases the output at once and keeps the flag.
- R8: The periodic request is active when `per_req` is 1 and the periodic select (bits 2..0 of address 0xE) is nonzero. `irq_a_n` is low when either the periodic request or the daily alarm output is active. Bit 2 of 0xF reads the periodic activity and ignores writes.
- R9: Alarm registers sit at 0x8 weekly minute (7 bits), 0x9 weekly hour (6 bits), 0xA weekly day-of-week (3 bits), 0xB daily minute (7 bits) and 0xC daily hour (6 bits). Bits above each width are dropped on write and read as 0. Bits 5..3 of 0xE read 0. Unmapped addresses read 0.
- R10: A match while the alarm's enable is 0 does not set its flag.
- R11: When a new match and a write of 0 to the same flag happen in one cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| now_dow | input | 3 | Current day-of-week, 0 to 6 |
| now_hour | input | 6 | Current hour, BCD |
| now_min | input | 7 | Current minute, BCD |
| per_req | input | 1 | Periodic interrupt request, active high |
| addr | input | 4 | Register address for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| irq_a_n | output | 1 | Active-low interrupt, daily alarm OR periodic |
| irq_b_n | output | 1 | Active-low interrupt, weekly alarm |

## Verification
The bench builds the block with its default field widths: a 3-bit day, a 6-bit hour, a 7-bit minute and an 8-bit register port. With these widths the masking of over-wide alarm writes and the 0x8 to 0xF address map can be tested at their real bit positions. During the random phase, time values are drawn from a small pool around the programmed alarms. This keeps matches, repeated matches within one minute, and same-cycle set-and-clear collisions frequent rather than rare.

// File: rtl/rtc_alm_pkg.sv
// Shared register map and bit positions for the RTC alarm interrupt block.
// Assumes a 4-bit register address space; positions are fixed by software.
package rtc_alm_pkg;
    localparam logic [3:0] A_WK_MIN  = 4'h8;
    localparam logic [3:0] A_WK_HOUR = 4'h9;
    localparam logic [3:0] A_WK_DOW  = 4'hA;
    localparam logic [3:0] A_DY_MIN  = 4'hB;
    localparam logic [3:0] A_DY_HOUR = 4'hC;
    localparam logic [3:0] A_CTRL1   = 4'hE;
    localparam logic [3:0] A_CTRL2   = 4'hF;

    localparam int EN_WK_BIT  = 7;
    localparam int EN_DY_BIT  = 6;
    localparam int FLG_DY_BIT = 0;
    localparam int FLG_WK_BIT = 1;
    localparam int FLG_PER_BIT = 2;
endpackage

// File: rtl/alm_cmp.sv
// Alarm comparator: compares a packed current-time key with a preset key and
// emits a one-cycle pulse on the clock where equality first appears.
// Assumes the key fields are already concatenated by the caller.
module alm_cmp #(
    parameter int KEY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] cur_key,
    input  logic [KEY_W-1:0] set_key,
    output logic             hit_rise
);
    logic hit_now;
    logic hit_q;

    assign hit_now  = (cur_key == set_key);
    assign hit_rise = hit_now && !hit_q;

    // Remember the previous comparison result for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= hit_now;
    end

    // R4: an edge pulse never lasts two cycles
    p_one_cycle_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit_rise |=> !hit_rise);
endmodule

// File: rtl/alm_flag.sv
// Sticky alarm flag: set by an armed match pulse, cleared by a clear request.
// A set in the same cycle as a clear wins. Assumes single-cycle pulses.
module alm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic hit_rise,
    input  logic clr_req,
    output logic flag
);
    logic set_ev;
    assign set_ev = hit_rise && arm;

    // Hold the flag; set has priority over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_ev)  flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end

    // R5: a clear without a competing set empties the flag
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !(hit_rise && arm)) |=> !flag);
    // R11: an armed match always leaves the flag set
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_rise && arm) |=> flag);
    // R10: a flag only rises if it was armed
    p_needs_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(arm));
    // R5: with no event the flag holds
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_rise && !clr_req) |=> $stable(flag));
endmodule

// File: rtl/alm_regs.sv
// Register file: alarm presets, control-1 enables and periodic select,
// control-2 flag clear decode, and the combinational read multiplexer.
// Assumes flags are held elsewhere and fed back for reads.
module alm_regs
    import rtc_alm_pkg::*;
#(
    parameter int DOW_W  = 3,
    parameter int HOUR_W = 6,
    parameter int MIN_W  = 7,
    parameter int SEL_W  = 3,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              flg_wk,
    input  logic              flg_dy,
    input  logic              per_act,
    output logic [DATA_W-1:0] rd_data,
    output logic [DOW_W-1:0]  wk_dow,
    output logic [HOUR_W-1:0] wk_hour,
    output logic [MIN_W-1:0]  wk_min,
    output logic [HOUR_W-1:0] dy_hour,
    output logic [MIN_W-1:0]  dy_min,
    output logic              en_wk,
    output logic              en_dy,
    output logic [SEL_W-1:0]  per_sel,
    output logic              clr_wk,
    output logic              clr_dy
);
    logic wr_c2;
    assign wr_c2  = wr_en && (addr == A_CTRL2);
    assign clr_wk = wr_c2 && !wr_data[FLG_WK_BIT];
    assign clr_dy = wr_c2 && !wr_data[FLG_DY_BIT];

    // Store alarm presets and control-1 fields on writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wk_dow <= '0; wk_hour <= '0; wk_min <= '0;
            dy_hour <= '0; dy_min <= '0;
            en_wk <= 1'b0; en_dy <= 1'b0; per_sel <= '0;
        end else if (wr_en) begin
            case (addr)
                A_WK_MIN:  wk_min  <= wr_data[MIN_W-1:0];
                A_WK_HOUR: wk_hour <= wr_data[HOUR_W-1:0];
                A_WK_DOW:  wk_dow  <= wr_data[DOW_W-1:0];
                A_DY_MIN:  dy_min  <= wr_data[MIN_W-1:0];
                A_DY_HOUR: dy_hour <= wr_data[HOUR_W-1:0];
                A_CTRL1: begin
                    en_wk   <= wr_data[EN_WK_BIT];
                    en_dy   <= wr_data[EN_DY_BIT];
                    per_sel <= wr_data[SEL_W-1:0];
                end
                default: ;
            endcase
        end
    end

    // Select the read value for the current address.
    always_comb begin
        rd_data = '0;
        case (addr)
            A_WK_MIN:  rd_data[MIN_W-1:0]  = wk_min;
            A_WK_HOUR: rd_data[HOUR_W-1:0] = wk_hour;
            A_WK_DOW:  rd_data[DOW_W-1:0]  = wk_dow;
            A_DY_MIN:  rd_data[MIN_W-1:0]  = dy_min;
            A_DY_HOUR: rd_data[HOUR_W-1:0] = dy_hour;
            A_CTRL1: begin
                rd_data[EN_WK_BIT]  = en_wk;
                rd_data[EN_DY_BIT]  = en_dy;
                rd_data[SEL_W-1:0]  = per_sel;
            end
            A_CTRL2: begin
                rd_data[FLG_WK_BIT]  = flg_wk;
                rd_data[FLG_DY_BIT]  = flg_dy;
                rd_data[FLG_PER_BIT] = per_act;
            end
            default: ;
        endcase
    end

    // R1: the first cycle after reset shows cleared controls
    p_ctrl_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!en_wk && !en_dy && per_sel == '0));
    // R9: a day-of-week write keeps only the low field bits
    p_dow_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_WK_DOW) |=> (wk_dow == $past(wr_data[DOW_W-1:0])));
    // R6: flag clears never disturb the enables
    p_clear_keeps_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CTRL2) |=> ($stable(en_wk) && $stable(en_dy)));
endmodule

// File: rtl/rtc_alarm_irq.sv
// Top of the RTC alarm interrupt block. Two alarm channels (weekly with
// day-of-week, daily without) each feed a sticky flag; outputs are active
// low. Line A merges the daily alarm with an external periodic request.
// Assumes time inputs are stable BCD values synchronous to clk.
module rtc_alarm_irq #(
    parameter int DOW_W  = 3,
    parameter int HOUR_W = 6,
    parameter int MIN_W  = 7,
    parameter int SEL_W  = 3,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DOW_W-1:0]  now_dow,
    input  logic [HOUR_W-1:0] now_hour,
    input  logic [MIN_W-1:0]  now_min,
    input  logic              per_req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_a_n,
    output logic              irq_b_n
);
    localparam int WK_KEY_W = DOW_W + HOUR_W + MIN_W;
    localparam int DY_KEY_W = HOUR_W + MIN_W;

    logic [DOW_W-1:0]  wk_dow;
    logic [HOUR_W-1:0] wk_hour, dy_hour;
    logic [MIN_W-1:0]  wk_min, dy_min;
    logic [SEL_W-1:0]  per_sel;
    logic en_wk, en_dy, clr_wk, clr_dy;
    logic hit_wk, hit_dy, flg_wk, flg_dy, per_act;

    assign per_act = per_req && (per_sel != '0);

    alm_regs #(
        .DOW_W(DOW_W), .HOUR_W(HOUR_W), .MIN_W(MIN_W),
        .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .flg_wk(flg_wk), .flg_dy(flg_dy),
        .per_act(per_act), .rd_data(rd_data), .wk_dow(wk_dow),
        .wk_hour(wk_hour), .wk_min(wk_min), .dy_hour(dy_hour),
        .dy_min(dy_min), .en_wk(en_wk), .en_dy(en_dy),
        .per_sel(per_sel), .clr_wk(clr_wk), .clr_dy(clr_dy)
    );

    alm_cmp #(.KEY_W(WK_KEY_W)) u_cmp_wk (
        .clk(clk), .rst_n(rst_n),
        .cur_key({now_dow, now_hour, now_min}),
        .set_key({wk_dow, wk_hour, wk_min}),
        .hit_rise(hit_wk)
    );

    alm_cmp #(.KEY_W(DY_KEY_W)) u_cmp_dy (
        .clk(clk), .rst_n(rst_n),
        .cur_key({now_hour, now_min}),
        .set_key({dy_hour, dy_min}),
        .hit_rise(hit_dy)
    );

    alm_flag u_flag_wk (
        .clk(clk), .rst_n(rst_n), .arm(en_wk),
        .hit_rise(hit_wk), .clr_req(clr_wk), .flag(flg_wk)
    );

    alm_flag u_flag_dy (
        .clk(clk), .rst_n(rst_n), .arm(en_dy),
        .hit_rise(hit_dy), .clr_req(clr_dy), .flag(flg_dy)
    );

    assign irq_b_n = !(flg_wk && en_wk);
    assign irq_a_n = !((flg_dy && en_dy) || per_act);

    // R1: outputs are idle on the first cycle out of reset
    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (irq_a_n && irq_b_n));
    // R8: an active periodic request always pulls line A low
    p_periodic_share_r8: assert property (@(posedge clk) disable iff (!rst_n)
        per_act |-> !irq_a_n);
    // R2: an armed weekly match lowers line B on the next cycle
    p_weekly_fires_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_wk && en_wk && !(wr_en && addr == rtc_alm_pkg::A_CTRL1)) |=> !irq_b_n);
    // R7: releasing the enable frees line B while the flag stays
    p_enable_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_wk && !en_wk) |-> irq_b_n);
endmodule

// File: tb/tb_rtc_alarm_irq.sv
`timescale 1ns/1ps
// Bench: behavioural reference model updated on each rising edge and
// compared a few ns later, plus directed checks per requirement.
module tb_rtc_alarm_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] now_dow = '0;
    logic [5:0] now_hour = '0;
    logic [6:0] now_min = '0;
    logic       per_req = 1'b0;
    logic [3:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq_a_n, irq_b_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit run_cmp = 1'b0;

    always #4 clk = ~clk;

    rtc_alarm_irq dut (
        .clk(clk), .rst_n(rst_n), .now_dow(now_dow), .now_hour(now_hour),
        .now_min(now_min), .per_req(per_req), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq_a_n(irq_a_n),
        .irq_b_n(irq_b_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model state
    int m_wm, m_wh, m_wd, m_dm, m_dh, m_sel;
    bit m_ewk, m_edy, m_fw, m_fd, m_pw, m_pd;

    function automatic int model_rd(input int a);
        case (a)
            8:  return m_wm;
            9:  return m_wh;
            10: return m_wd;
            11: return m_dm;
            12: return m_dh;
            14: return (int'(m_ewk) << 7) | (int'(m_edy) << 6) | m_sel;
            15: return (int'(per_req && m_sel != 0) << 2) | (int'(m_fw) << 1) | int'(m_fd);
            default: return 0;
        endcase
    endfunction

    // Advance the model at each edge, then compare a little later.
    always @(posedge clk) begin
        bit mw, md, nfw, nfd;
        if (!rst_n) begin
            m_wm = 0; m_wh = 0; m_wd = 0; m_dm = 0; m_dh = 0; m_sel = 0;
            m_ewk = 0; m_edy = 0; m_fw = 0; m_fd = 0; m_pw = 0; m_pd = 0;
        end else begin
            mw = (now_dow == m_wd) && (now_hour == m_wh) && (now_min == m_wm);
            md = (now_hour == m_dh) && (now_min == m_dm);
            nfw = m_fw; nfd = m_fd;
            if (mw && !m_pw && m_ewk) nfw = 1;
            else if (wr_en && addr == 15 && !wr_data[1]) nfw = 0;
            if (md && !m_pd && m_edy) nfd = 1;
            else if (wr_en && addr == 15 && !wr_data[0]) nfd = 0;
            m_pw = mw; m_pd = md;
            if (wr_en) begin
                case (addr)
                    8:  m_wm = wr_data & 8'h7F;
                    9:  m_wh = wr_data & 8'h3F;
                    10: m_wd = wr_data & 8'h07;
                    11: m_dm = wr_data & 8'h7F;
                    12: m_dh = wr_data & 8'h3F;
                    14: begin m_ewk = wr_data[7]; m_edy = wr_data[6]; m_sel = wr_data[2:0]; end
                    default: ;
                endcase
            end
            m_fw = nfw; m_fd = nfd;
        end
        #3;
        if (run_cmp && !done) begin
            chk(irq_b_n == !(m_fw && m_ewk), "R2 R7 model irq_b_n", irq_b_n, !(m_fw && m_ewk));
            chk(irq_a_n == !((m_fd && m_edy) || (per_req && m_sel != 0)),
                "R3 R8 model irq_a_n", irq_a_n, !((m_fd && m_edy) || (per_req && m_sel != 0)));
            chk(rd_data == model_rd(addr), "R9 model rd_data", rd_data, model_rd(addr));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        addr = a[3:0]; wr_data = d[7:0]; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic rd(input int a, output int v);
        addr = a[3:0];
        #1;
        v = rd_data;
    endtask

    task automatic set_time(input int d, input int h, input int m);
        now_dow = d[2:0]; now_hour = h[5:0]; now_min = m[6:0];
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int v;
        cyc(3);
        rst_n = 1'b1;
        #1;
        run_cmp = 1'b1;
        // R1 reset state
        chk(irq_a_n == 1, "R1 irq_a_n idle", irq_a_n, 1);
        chk(irq_b_n == 1, "R1 irq_b_n idle", irq_b_n, 1);
        rd(14, v); chk(v == 0, "R1 control 0xE", v, 0);
        rd(15, v); chk(v == 0, "R1 flags 0xF", v, 0);
        rd(9, v);  chk(v == 0, "R1 alarm hour", v, 0);

        // R9 register map and masking
        wr(8, 'hFF); rd(8, v); chk(v == 'h7F, "R9 minute mask", v, 'h7F);
        wr(8, 'h30); wr(9, 'h12); wr(10, 'hFB); wr(11, 'h45); wr(12, 'h07);
        rd(9, v);  chk(v == 'h12, "R9 weekly hour", v, 'h12);
        rd(10, v); chk(v == 'h3, "R9 dow mask", v, 'h3);
        rd(3, v);  chk(v == 0, "R9 unmapped 0x3", v, 0);
        rd(13, v); chk(v == 0, "R9 unmapped 0xD", v, 0);
        wr(14, 'h38); rd(14, v); chk(v == 0, "R9 ctrl1 reserved bits", v, 0);

        // R10 match while disabled
        cyc(1); set_time(3, 'h12, 'h30); cyc(2);
        rd(15, v); chk(v == 0, "R10 flag stays clear", v, 0);
        chk(irq_b_n == 1, "R10 irq_b_n idle", irq_b_n, 1);
        set_time(0, 0, 0);
        wr(14, 'hC0);

        // R2 day-of-week mismatch, then full match
        set_time(4, 'h12, 'h30); cyc(1);
        rd(15, v); chk(v == 0, "R2 dow mismatch no flag", v, 0);
        set_time(3, 'h12, 'h30); cyc(1);
        chk(irq_b_n == 0, "R2 irq_b_n low", irq_b_n, 0);
        rd(15, v); chk(v == 2, "R2 weekly flag", v, 2);
        chk(irq_a_n == 1, "R2 line A untouched", irq_a_n, 1);

        // R5 clear by writing 0, R4 no re-set within same match
        wr(15, 'hFD);
        chk(irq_b_n == 1, "R5 irq_b_n released", irq_b_n, 1);
        rd(15, v); chk(v == 0, "R5 weekly flag cleared", v, 0);
        cyc(3); rd(15, v); chk(v == 0, "R4 no re-set in same minute", v, 0);

        // R3 daily match ignores day-of-week
        set_time(3, 'h07, 'h45); cyc(1);
        chk(irq_a_n == 0, "R3 irq_a_n low", irq_a_n, 0);
        rd(15, v); chk(v == 1, "R3 daily flag", v, 1);
        wr(15, 'hFF); rd(15, v); chk(v == 1, "R5 writing 1 keeps flag", v, 1);

        // R7 enable gating
        wr(14, 'h80);
        chk(irq_a_n == 1, "R7 disable releases A", irq_a_n, 1);
        rd(15, v); chk(v == 1, "R7 flag kept", v, 1);
        wr(14, 'hC0);
        chk(irq_a_n == 0, "R7 re-enable asserts A", irq_a_n, 0);

        // R6 clear keeps enable; next match re-fires
        wr(15, 'hFE);
        chk(irq_a_n == 1, "R5 daily clear releases A", irq_a_n, 1);
        rd(14, v); chk(v == 'hC0, "R6 enables unchanged", v, 'hC0);
        set_time(3, 'h07, 'h46); cyc(1);
        set_time(3, 'h07, 'h45); cyc(1);
        rd(15, v); chk(v == 1, "R6 re-armed alarm sets", v, 1);
        wr(15, 0);
        set_time(3, 'h07, 'h46); cyc(1);

        // R11 set and clear in one cycle
        set_time(3, 'h07, 'h45);
        addr = 4'hF; wr_data = 8'h00; wr_en = 1'b1;
        cyc(1); wr_en = 1'b0; #1;
        rd(15, v); chk(v == 1, "R11 set wins over clear", v, 1);
        wr(15, 0);
        cyc(1); set_time(0, 0, 0); cyc(1);

        // R8 periodic sharing of line A
        wr(14, 'hC3); per_req = 1'b1; #1;
        chk(irq_a_n == 0, "R8 periodic pulls A", irq_a_n, 0);
        rd(15, v); chk(v == 4, "R8 periodic flag bit", v, 4);
        cyc(1); per_req = 1'b0; #1;
        chk(irq_a_n == 1, "R8 periodic released", irq_a_n, 1);
        wr(14, 'hC0); per_req = 1'b1; #1;
        chk(irq_a_n == 1, "R8 select 0 disables periodic", irq_a_n, 1);
        rd(15, v); chk(v == 0, "R8 periodic bit off", v, 0);
        wr(14, 'hC3); per_req = 1'b0;
        set_time(3, 'h07, 'h45); cyc(1); #1;
        chk(irq_a_n == 0, "R8 daily alone on A", irq_a_n, 0);
        per_req = 1'b1; rd(15, v);
        chk(v == 5, "R8 both sources visible", v, 5);
        chk(irq_a_n == 0, "R8 combined A low", irq_a_n, 0);
        wr(15, 0); cyc(1); per_req = 1'b0;

        // Random phase, compared every clock by the model
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            set_time($urandom_range(2, 4),
                     ($urandom_range(0, 2) == 0) ? 'h07 : 'h12,
                     ($urandom_range(0, 2) == 0) ? 'h45 : 'h30);
            per_req = ($urandom_range(0, 3) == 0);
            addr = 4'($urandom_range(0, 15));
            wr_en = ($urandom_range(0, 3) == 0);
            wr_data = 8'($urandom);
            if (wr_en && addr >= 8 && addr <= 12) begin
                wr_en = 1'b0;
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
        cyc(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule